// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for the execute stage of a five-stage in-order pipeline, where each operand comes from. Four execute-stage consumers are served: the first ALU input, the second ALU input, the store-data path toward data memory and the branch zero-test input. For each one the block picks between three candidates. The first is the register-file value that travelled with the instruction. The second is the ALU result sitting in the execute/memory pipeline register. The third is the result sitting in the memory/writeback register, which is either an ALU result or data returned by a load.

The block reads the instruction words of the three pipeline registers and decodes them. From the execute instruction it finds which source fields are consumed. From the two older instructions it finds which register each one will write. It outputs a select code for each consumer and the resulting forwarded operand value. The whole block is combinational and is meant to sit directly in front of the execute-stage multiplexers. Stalling, the register file and the ALU lie outside it.

Instruction word layout, with bit 0 as the most significant bit: bits 0–5 (word[31:26]) hold the opcode, bits 6–10 (word[25:21]) hold the first source, bits 11–15 (word[20:16]) hold the second source or immediate-form target, and bits 16–20 (word[15:11]) hold the register-register target.

Top module: `fwd_unit`

## Requirements
- R1: Each select output encodes 0 = register-file value, 1 = execute/memory ALU result, 2 = memory/writeback result. When no older instruction matches, every select is 0 and every operand output equals its register-file value (first source for ALU A and zero-test, second source for ALU B and store data).
- R2: If the execute/memory instruction writes register r (r not 0) and a consumer reads r, that consumer's select is 1 and its value equals the execute/memory ALU result.
- R3: If only the memory/writeback instruction writes the consumed register, the select is 2. The value is the load data when that instruction is a load (opcode 6'h23); otherwise it is the writeback ALU result.
- R4: When both older instructions write the consumed register, the execute/memory value wins (select 1).
- R5: A load (opcode 6'h23) in the execute/memory register is never a source. A matching memory/writeback writer may still forward.
- R6: The written register depends on format. Register-register ALU instructions (opcode 6'h00) write word[15:11]. Immediate ALU instructions (opcode 6'b001xxx) and loads write word[20:16].
- R7: Stores (6'h2B), branches (6'h04) and every other opcode write nothing and never act as a source.
- R8: Register 0 is never forwarded; a consumer reading register 0 keeps select 0.
- R9: Consumers are gated by opcode:
  - ALU A forwards for register-register, immediate, load and store instructions.
  - The zero-test forwards only for branches.
  - ALU B forwards only for register-register instructions.
  - Store data forwards only for stores.
  - In all other cases the select is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| exInstr | input | 32 | Instruction word in the decode/execute register |
| exRs1Val | input | DATA_W | Register-file value of the first source |
| exRs2Val | input | DATA_W | Register-file value of the second source |
| memInstr | input | 32 | Instruction word in the execute/memory register |
| memAluOut | input | DATA_W | ALU result held in the execute/memory register |
| wbInstr | input | 32 | Instruction word in the memory/writeback register |
| wbAluOut | input | DATA_W | ALU result held in the memory/writeback register |
| wbLoadData | input | DATA_W | Load data held in the memory/writeback register |
| aluASel | output | 2 | Source select for ALU input A |
| aluBSel | output | 2 | Source select for ALU input B |
| storeSel | output | 2 | Source select for store data |
| zeroSel | output | 2 | Source select for the zero-test input |
| aluAVal | output | DATA_W | Forwarded ALU A operand |
| aluBVal | output | DATA_W | Forwarded ALU B operand |
| storeVal | output | DATA_W | Forwarded store data |
| zeroVal | output | DATA_W | Forwarded zero-test operand |

## Verification
The bench targets the cases a plausible bug would get wrong, and each case names its failure mode.

- **Both older instructions write the same register.** A design with reversed priority hands ALU A the stale writeback value.
- **Load in the execute/memory register.** A design that treats it like an ALU writer forwards an address instead of data.
- **Register-register word with different values in the two target fields.** A design decoding the wrong field forwards to the wrong consumer.
- **Writes to register 0.** These must be ignored.
- **Store and branch words in the older registers.** These must not be taken as writers.
- **Consumer gating.** A store must not pull ALU B forward, and a branch must not forward into ALU A.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int ILEN = 32;
  localparam int RIDX_W = 5;
  localparam int OP_W = 6;

  typedef logic [OP_W-1:0]   opcode_t;
  typedef logic [RIDX_W-1:0] regIdx_t;

  localparam opcode_t OP_RR     = 6'h00;
  localparam opcode_t OP_BRANCH = 6'h04;
  localparam opcode_t OP_LOAD   = 6'h23;
  localparam opcode_t OP_STORE  = 6'h2B;

  typedef enum logic [1:0] {
    SEL_REG   = 2'd0,
    SEL_EXMEM = 2'd1,
    SEL_MEMWB = 2'd2
  } fwdSel_e;

  typedef struct packed {
    fwdSel_e aluA;
    fwdSel_e aluB;
    fwdSel_e store;
    fwdSel_e zero;
    logic    wbIsLoad;
  } fwdStrobes_t;

  function automatic opcode_t opOf(input logic [ILEN-1:0] w);
    return w[ILEN-1 -: OP_W];
  endfunction

  function automatic regIdx_t srcAOf(input logic [ILEN-1:0] w);
    return w[ILEN-OP_W-1 -: RIDX_W];
  endfunction

  function automatic regIdx_t srcBOf(input logic [ILEN-1:0] w);
    return w[ILEN-OP_W-RIDX_W-1 -: RIDX_W];
  endfunction

  function automatic logic isImmAlu(input opcode_t op);
    return op[OP_W-1 -: 3] == 3'b001;
  endfunction

  function automatic logic isAluWriter(input opcode_t op);
    return (op == OP_RR) || isImmAlu(op);
  endfunction

  // register-register targets sit in the third field, others in the second
  function automatic regIdx_t destOf(input logic [ILEN-1:0] w);
    if (opOf(w) == OP_RR) return w[ILEN-OP_W-2*RIDX_W-1 -: RIDX_W];
    return srcBOf(w);
  endfunction
endpackage

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
  import fwd_pkg::*;
(
  input  logic [ILEN-1:0] exInstr,
  input  logic [ILEN-1:0] memInstr,
  input  logic [ILEN-1:0] wbInstr,
  output fwdStrobes_t     strobes
);
  opcode_t exOp, memOp, wbOp;
  regIdx_t exSrcA, exSrcB, memDest, wbDest;
  logic    memWrites, wbWrites;
  logic    useA, useB, useStore, useZero;

  assign exOp    = opOf(exInstr);
  assign memOp   = opOf(memInstr);
  assign wbOp    = opOf(wbInstr);
  assign exSrcA  = srcAOf(exInstr);
  assign exSrcB  = srcBOf(exInstr);
  assign memDest = destOf(memInstr);
  assign wbDest  = destOf(wbInstr);

  // loads in the execute/memory register have no data yet
  assign memWrites = isAluWriter(memOp) && (memDest != '0);
  assign wbWrites  = (isAluWriter(wbOp) || (wbOp == OP_LOAD)) && (wbDest != '0);

  assign useA     = isAluWriter(exOp) || (exOp == OP_LOAD) || (exOp == OP_STORE);
  assign useZero  = (exOp == OP_BRANCH);
  assign useB     = (exOp == OP_RR);
  assign useStore = (exOp == OP_STORE);

  function automatic fwdSel_e pick(input logic used, input regIdx_t src,
                                   input logic mw, input regIdx_t md,
                                   input logic ww, input regIdx_t wd);
    if (!used || src == '0) return SEL_REG;
    if (mw && md == src)    return SEL_EXMEM;
    if (ww && wd == src)    return SEL_MEMWB;
    return SEL_REG;
  endfunction

  always_comb begin
    strobes.aluA     = pick(useA,     exSrcA, memWrites, memDest, wbWrites, wbDest);
    strobes.zero     = pick(useZero,  exSrcA, memWrites, memDest, wbWrites, wbDest);
    strobes.aluB     = pick(useB,     exSrcB, memWrites, memDest, wbWrites, wbDest);
    strobes.store    = pick(useStore, exSrcB, memWrites, memDest, wbWrites, wbDest);
    strobes.wbIsLoad = (wbOp == OP_LOAD);
  end

  logic unusedLowBits;
  assign unusedLowBits = ^{exInstr[ILEN-OP_W-2*RIDX_W-1:0],
                           memInstr[ILEN-OP_W-3*RIDX_W-1:0],
                           wbInstr[ILEN-OP_W-3*RIDX_W-1:0]};

  always_comb begin
    p_zero_reg_never_r8: assert (srcAOf(exInstr) != '0 ||
        (strobes.aluA == SEL_REG && strobes.zero == SEL_REG))
      else $error("register 0 forwarded");
    p_load_not_source_r5: assert (opOf(memInstr) != OP_LOAD ||
        (strobes.aluA != SEL_EXMEM && strobes.aluB != SEL_EXMEM &&
         strobes.store != SEL_EXMEM && strobes.zero != SEL_EXMEM))
      else $error("load in execute/memory used as source");
    p_nonwriter_wb_r7: assert (!(opOf(wbInstr) == OP_STORE || opOf(wbInstr) == OP_BRANCH) ||
        (strobes.aluA != SEL_MEMWB && strobes.aluB != SEL_MEMWB &&
         strobes.store != SEL_MEMWB && strobes.zero != SEL_MEMWB))
      else $error("non-writer in memory/writeback used as source");
    p_b_gated_r9: assert (opOf(exInstr) == OP_RR || strobes.aluB == SEL_REG)
      else $error("ALU B forwarded for non register-register op");
  end
endmodule

// File: rtl/fwd_datapath.sv
module fwd_datapath
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fwdStrobes_t       strobes,
  input  logic [DATA_W-1:0] rs1Val,
  input  logic [DATA_W-1:0] rs2Val,
  input  logic [DATA_W-1:0] memAluOut,
  input  logic [DATA_W-1:0] wbAluOut,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [DATA_W-1:0] aluAVal,
  output logic [DATA_W-1:0] aluBVal,
  output logic [DATA_W-1:0] storeVal,
  output logic [DATA_W-1:0] zeroVal
);
  localparam int NDEST = 4;

  fwdSel_e           selArr  [NDEST];
  logic [DATA_W-1:0] baseArr [NDEST];
  logic [DATA_W-1:0] outArr  [NDEST];
  logic [DATA_W-1:0] wbValue;

  assign wbValue = strobes.wbIsLoad ? wbLoadData : wbAluOut;

  assign selArr[0]  = strobes.aluA;   assign baseArr[0] = rs1Val;
  assign selArr[1]  = strobes.aluB;   assign baseArr[1] = rs2Val;
  assign selArr[2]  = strobes.store;  assign baseArr[2] = rs2Val;
  assign selArr[3]  = strobes.zero;   assign baseArr[3] = rs1Val;

  for (genvar d = 0; d < NDEST; d++) begin : g_mux
    always_comb begin
      case (selArr[d])
        SEL_EXMEM: outArr[d] = memAluOut;
        SEL_MEMWB: outArr[d] = wbValue;
        default:   outArr[d] = baseArr[d];
      endcase
    end

    always_comb begin
      p_reg_path_r1: assert (selArr[d] != SEL_REG || outArr[d] == baseArr[d])
        else $error("register path corrupted on consumer %0d", d);
    end
  end

  assign aluAVal  = outArr[0];
  assign aluBVal  = outArr[1];
  assign storeVal = outArr[2];
  assign zeroVal  = outArr[3];
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       exInstr,
  input  logic [DATA_W-1:0] exRs1Val,
  input  logic [DATA_W-1:0] exRs2Val,
  input  logic [31:0]       memInstr,
  input  logic [DATA_W-1:0] memAluOut,
  input  logic [31:0]       wbInstr,
  input  logic [DATA_W-1:0] wbAluOut,
  input  logic [DATA_W-1:0] wbLoadData,
  output logic [1:0]        aluASel,
  output logic [1:0]        aluBSel,
  output logic [1:0]        storeSel,
  output logic [1:0]        zeroSel,
  output logic [DATA_W-1:0] aluAVal,
  output logic [DATA_W-1:0] aluBVal,
  output logic [DATA_W-1:0] storeVal,
  output logic [DATA_W-1:0] zeroVal
);
  fwdStrobes_t strobes;

  fwd_ctrl u_ctrl (
    .exInstr (exInstr),
    .memInstr(memInstr),
    .wbInstr (wbInstr),
    .strobes (strobes)
  );

  fwd_datapath #(.DATA_W(DATA_W)) u_dp (
    .strobes   (strobes),
    .rs1Val    (exRs1Val),
    .rs2Val    (exRs2Val),
    .memAluOut (memAluOut),
    .wbAluOut  (wbAluOut),
    .wbLoadData(wbLoadData),
    .aluAVal   (aluAVal),
    .aluBVal   (aluBVal),
    .storeVal  (storeVal),
    .zeroVal   (zeroVal)
  );

  assign aluASel  = strobes.aluA;
  assign aluBSel  = strobes.aluB;
  assign storeSel = strobes.store;
  assign zeroSel  = strobes.zero;
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  localparam logic [31:0] RS1V = 32'h1111_0001;
  localparam logic [31:0] RS2V = 32'h2222_0002;
  localparam logic [31:0] MEMV = 32'hAAAA_0003;
  localparam logic [31:0] WBAV = 32'hBBBB_0004;
  localparam logic [31:0] WBLV = 32'hCCCC_0005;
  localparam logic [31:0] NOP  = {6'h3F, 26'h0};

  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [31:0] exInstr, memInstr, wbInstr;
  logic [31:0] exRs1Val, exRs2Val, memAluOut, wbAluOut, wbLoadData;
  logic [1:0]  aluASel, aluBSel, storeSel, zeroSel;
  logic [31:0] aluAVal, aluBVal, storeVal, zeroVal;

  int checks = 0, fails = 0;
  bit done = 0;

  fwd_unit dut (.*);

  function automatic logic [31:0] rr(input int s1, input int s2, input int rd);
    return {6'h00, 5'(s1), 5'(s2), 5'(rd), 11'h0};
  endfunction
  function automatic logic [31:0] iw(input logic [5:0] op, input int s1, input int rt);
    return {op, 5'(s1), 5'(rt), 16'h0};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] ex, input logic [31:0] mem, input logic [31:0] wb);
    @(posedge clk); #1;
    exInstr = ex; memInstr = mem; wbInstr = wb;
    @(negedge clk);
  endtask

  function automatic logic [31:0] expVal(input int sel, input logic [31:0] base, input logic [31:0] wbv);
    return sel == 1 ? MEMV : (sel == 2 ? wbv : base);
  endfunction

  // compare all four selects and values; wbv is the expected writeback value
  task automatic expectAll(input string req, input int a, input int b, input int s, input int z,
                           input logic [31:0] wbv);
    chk(req, "aluASel",  32'(aluASel),  32'(a));
    chk(req, "aluBSel",  32'(aluBSel),  32'(b));
    chk(req, "storeSel", 32'(storeSel), 32'(s));
    chk(req, "zeroSel",  32'(zeroSel),  32'(z));
    chk(req, "aluAVal",  aluAVal,  expVal(a, RS1V, wbv));
    chk(req, "aluBVal",  aluBVal,  expVal(b, RS2V, wbv));
    chk(req, "storeVal", storeVal, expVal(s, RS2V, wbv));
    chk(req, "zeroVal",  zeroVal,  expVal(z, RS1V, wbv));
  endtask

  task automatic t_idle;  // R1
    drive(rr(3, 4, 9), NOP, NOP);
    expectAll("R1", 0, 0, 0, 0, WBAV);
  endtask

  task automatic t_exmem;  // R2
    drive(rr(3, 4, 9), rr(1, 2, 3), NOP);
    expectAll("R2", 1, 0, 0, 0, WBAV);
    drive(rr(3, 4, 9), iw(6'h09, 1, 4), NOP);
    expectAll("R2", 0, 1, 0, 0, WBAV);
  endtask

  task automatic t_memwb;  // R3
    drive(rr(3, 4, 9), NOP, iw(6'h0C, 1, 4));
    expectAll("R3", 0, 2, 0, 0, WBAV);
    drive(rr(3, 4, 9), NOP, iw(6'h23, 1, 3));
    expectAll("R3", 2, 0, 0, 0, WBLV);
  endtask

  task automatic t_priority;  // R4
    drive(rr(5, 5, 9), rr(1, 2, 5), rr(1, 2, 5));
    expectAll("R4", 1, 1, 0, 0, WBAV);
  endtask

  task automatic t_loadInMem;  // R5
    drive(rr(6, 7, 9), iw(6'h23, 1, 6), NOP);
    expectAll("R5", 0, 0, 0, 0, WBAV);
    drive(rr(6, 7, 9), iw(6'h23, 1, 6), rr(1, 2, 6));
    expectAll("R5", 2, 0, 0, 0, WBAV);
  endtask

  task automatic t_format;  // R6
    drive(rr(8, 7, 9), rr(0, 8, 7), NOP);
    expectAll("R6", 0, 1, 0, 0, WBAV);
    drive(rr(9, 7, 1), {6'h08, 5'd0, 5'd9, 5'd7, 11'd0}, NOP);
    expectAll("R6", 1, 0, 0, 0, WBAV);
  endtask

  task automatic t_nonWriters;  // R7
    drive(rr(10, 11, 9), iw(6'h04, 1, 11), iw(6'h2B, 1, 10));
    expectAll("R7", 0, 0, 0, 0, WBAV);
    drive(rr(10, 11, 9), iw(6'h3E, 1, 10), {6'h3D, 5'd0, 5'd11, 5'd10, 11'd0});
    expectAll("R7", 0, 0, 0, 0, WBAV);
  endtask

  task automatic t_regZero;  // R8
    drive(rr(0, 0, 9), rr(1, 2, 0), iw(6'h23, 1, 0));
    expectAll("R8", 0, 0, 0, 0, WBLV);
  endtask

  task automatic t_usage;  // R9
    drive(iw(6'h2B, 11, 12), rr(1, 2, 12), rr(1, 2, 11));
    expectAll("R9", 2, 0, 1, 0, WBAV);
    drive(iw(6'h04, 12, 3), rr(1, 2, 12), NOP);
    expectAll("R9", 0, 0, 0, 1, WBAV);
    drive(iw(6'h0A, 13, 12), rr(1, 2, 12), rr(1, 2, 13));
    expectAll("R9", 2, 0, 0, 0, WBAV);
  endtask

  initial begin
    exInstr = NOP; memInstr = NOP; wbInstr = NOP;
    exRs1Val = RS1V; exRs2Val = RS2V; memAluOut = MEMV;
    wbAluOut = WBAV; wbLoadData = WBLV;
    @(negedge clk);
    expectAll("R1", 0, 0, 0, 0, WBAV);
    t_idle();
    t_exmem();
    t_memwb();
    t_priority();
    t_loadInMem();
    t_format();
    t_nonWriters();
    t_regZero();
    t_usage();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule